// File: doc/BRIEF.md
# Two-Way Time Synchronization Requester

This block is the node-side controller for a two-way clock synchronization exchange with a reference node. The reference node broadcasts a sync request once per synchronization interval. When the node sees one, it waits a random number of cycles. It then sends a sync message stamped with its local time and waits for an acknowledgment. The acknowledgment carries the reference node's receive and send times for that message.

If no acknowledgment arrives in time, the node sends the sync message again, up to a set number of times. It then gives up and raises a failure flag. When a matching acknowledgment is accepted, the block combines four timestamps:

- its own send time,
- the reference node's receive time,
- the reference node's send time,
- its own receive time.

From these it produces one offset sample and one one-way delay sample, and pulses a valid strobe. Drift filtering of the samples belongs to a later stage.

Messages use a simple valid/ready interface. Each message has a type field, a sequence number and timestamp fields. All timestamps are taken from the `local_time` input at the moment a message is handed over or accepted. Both message kinds have equal length, so fixed processing delays cancel out in the arithmetic.

Top module: `tsync_requester`

## Requirements
- R1: After reset, `tx_valid`, `sample_valid` and `sync_fail` are low and `tx_seq` is 0.
- R2: A message with `rx_type` = 0 (sync request) is accepted when the block is idle. With N = `rnd_in` & `BACKOFF_MASK`, `tx_valid` first rises N+1 cycles after the accepting edge. With `tx_ready` high, the send handshake therefore happens N+2 edges after the request edge.
- R3: While `tx_valid` is high, the outgoing message has `tx_type` = 1 and `tx_ts` equal to the current `local_time`. The message, including its sequence number, is held until `tx_ready` is high. The local send time is the `local_time` of the handshake cycle.
- R4: If no matching acknowledgment is accepted on the TIMEOUT+1 edges after a send handshake, the block sends again with the sequence number plus one. With `tx_ready` high, the next handshake follows TIMEOUT+2 edges after the previous one. A matching acknowledgment on the last of those edges is still accepted.
- R5: An acknowledgment is accepted only if `rx_type` = 2 and `rx_seq` equals the outstanding sequence number. Any other message received while waiting produces no sample and does not change the wait.
- R6: On accepting an acknowledgment, the block drives `sample_valid` high for exactly one cycle. Let f = t2−t1 and b = t4−t3, each a wrapped 32-bit signed difference. Then `sample_offset` = floor((f−b)/2) and `sample_delay` = floor((f+b)/2).
- R7: After MAX_RETRY resends with no acknowledgment, the block sets `sync_fail`, returns to idle and sends nothing more. `sync_fail` stays high until the next sync request is accepted.
- R8: A sync request that arrives while an exchange is in progress is ignored. It neither restarts nor shortens the backoff.
- R9: The sequence number advances by one after every accepted acknowledgment and every timeout, so each exchange uses a new number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_time | input | 32 | Free-running local timestamp |
| rnd_in | input | 16 | Random value, sampled when a sync request is accepted |
| rx_valid | input | 1 | Received message present this cycle |
| rx_type | input | 2 | Received type: 0 request, 1 sync, 2 acknowledgment |
| rx_seq | input | 8 | Received sequence number |
| rx_ts_recv | input | 32 | Reference receive time of the sync message (t2) |
| rx_ts_send | input | 32 | Reference send time of the acknowledgment (t3) |
| tx_valid | output | 1 | Outgoing sync message offered |
| tx_ready | input | 1 | Outgoing message taken this cycle |
| tx_type | output | 2 | Outgoing type, always 1 |
| tx_seq | output | 8 | Outgoing and outstanding sequence number |
| tx_ts | output | 32 | Local send timestamp (t1) |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_offset | output | 32 | Signed clock offset sample |
| sample_delay | output | 32 | Signed one-way delay sample |
| sync_fail | output | 1 | Retries exhausted in the last exchange |

## Verification
The assertions assume that:

- `tx_ready` may stall for any number of cycles;
- received messages last exactly one cycle;
- the reference never answers before the node's send handshake has completed.

The stimulus follows these rules. Every receive pulse is held for one cycle. Acknowledgments are only driven after a handshake has been observed, and their delay is drawn from $urandom within the timeout window, except in the timeout, last-chance and give-up cases. Stray messages are injected only while the block is waiting or backing off. These are the cases where the assertions expect them to have no effect.

// File: rtl/tsync_pkg.sv
`timescale 1ns/1ps
package tsync_pkg;
  localparam int TS_W  = 32;
  localparam int SEQ_W = 8;
  localparam int TY_W  = 2;

  localparam logic [TY_W-1:0] MT_REQ  = 2'd0;
  localparam logic [TY_W-1:0] MT_SYNC = 2'd1;
  localparam logic [TY_W-1:0] MT_ACK  = 2'd2;

  typedef logic [TS_W-1:0]  ts_t;
  typedef logic [SEQ_W-1:0] seq_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BACKOFF = 2'd1,
    ST_SEND    = 2'd2,
    ST_WAIT    = 2'd3
  } req_state_e;

  // Wrapped signed difference of two timestamps, widened by one bit.
  function automatic logic signed [TS_W:0] ts_span(input ts_t later, input ts_t earlier);
    ts_t d;
    d = later - earlier;
    return {d[TS_W-1], d};
  endfunction

  // Half of a 33-bit signed value, rounded toward minus infinity.
  function automatic ts_t ts_half(input logic signed [TS_W:0] v);
    logic signed [TS_W:0] h;
    h = v >>> 1;
    return TS_W'(h);
  endfunction
endpackage

// File: rtl/tsync_dcount.sv
`timescale 1ns/1ps
module tsync_dcount #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (dec && (cnt_q != '0))
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/tsync_calc.sv
`timescale 1ns/1ps
module tsync_calc
  import tsync_pkg::*;
(
  input  ts_t t_loc_tx,
  input  ts_t t_ref_rx,
  input  ts_t t_ref_tx,
  input  ts_t t_loc_rx,
  output ts_t offset,
  output ts_t delay
);
  logic signed [TS_W:0] fwd_span;
  logic signed [TS_W:0] bwd_span;
  logic signed [TS_W:0] diff_w;
  logic signed [TS_W:0] sum_w;

  always_comb begin
    fwd_span = ts_span(t_ref_rx, t_loc_tx);
    bwd_span = ts_span(t_loc_rx, t_ref_tx);
    diff_w   = fwd_span - bwd_span;
    sum_w    = fwd_span + bwd_span;
    offset   = ts_half(diff_w);
    delay    = ts_half(sum_w);
  end
endmodule

// File: rtl/tsync_requester.sv
`timescale 1ns/1ps
module tsync_requester
  import tsync_pkg::*;
#(
  parameter int              RND_W        = 16,
  parameter logic [RND_W-1:0] BACKOFF_MASK = 16'h003F,
  parameter int              TIMEOUT      = 40,
  parameter int              MAX_RETRY    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  local_time,
  input  logic [RND_W-1:0] rnd_in,
  input  logic             rx_valid,
  input  logic [TY_W-1:0]  rx_type,
  input  logic [SEQ_W-1:0] rx_seq,
  input  logic [TS_W-1:0]  rx_ts_recv,
  input  logic [TS_W-1:0]  rx_ts_send,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [TY_W-1:0]  tx_type,
  output logic [SEQ_W-1:0] tx_seq,
  output logic [TS_W-1:0]  tx_ts,
  output logic             sample_valid,
  output logic [TS_W-1:0]  sample_offset,
  output logic [TS_W-1:0]  sample_delay,
  output logic             sync_fail
);
  localparam int TMR_W = $clog2(TIMEOUT + 1) < 1 ? 1 : $clog2(TIMEOUT + 1);
  localparam int RTY_W = $clog2(MAX_RETRY + 2);

  req_state_e       st_q, st_d;
  seq_t             seq_q;
  ts_t              t1_q;
  logic [RTY_W-1:0] retry_q;
  logic             fail_q;
  logic             smp_v_q;
  ts_t              off_q, dly_q;

  // Named internal events, also observed by the bound checker.
  logic ev_req_take, ev_tx_fire, ev_ack_take, ev_timeout, ev_retry, ev_give_up;
  logic ack_hit, bo_zero, tmo_zero;
  ts_t  calc_off, calc_dly;

  assign ack_hit     = rx_valid && (rx_type == MT_ACK) && (rx_seq == seq_q);
  assign ev_req_take = (st_q == ST_IDLE) && rx_valid && (rx_type == MT_REQ);
  assign ev_tx_fire  = (st_q == ST_SEND) && tx_ready;
  assign ev_ack_take = (st_q == ST_WAIT) && ack_hit;
  assign ev_timeout  = (st_q == ST_WAIT) && !ack_hit && tmo_zero;
  assign ev_retry    = ev_timeout && (retry_q != RTY_W'(MAX_RETRY));
  assign ev_give_up  = ev_timeout && (retry_q == RTY_W'(MAX_RETRY));

  tsync_dcount #(.W(RND_W)) u_backoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_req_take),
    .load_val (rnd_in & BACKOFF_MASK),
    .dec      (st_q == ST_BACKOFF),
    .zero     (bo_zero)
  );

  tsync_dcount #(.W(TMR_W)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_tx_fire),
    .load_val (TMR_W'(TIMEOUT)),
    .dec      (st_q == ST_WAIT),
    .zero     (tmo_zero)
  );

  tsync_calc u_calc (
    .t_loc_tx (t1_q),
    .t_ref_rx (rx_ts_recv),
    .t_ref_tx (rx_ts_send),
    .t_loc_rx (local_time),
    .offset   (calc_off),
    .delay    (calc_dly)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (ev_req_take) st_d = ST_BACKOFF;
      ST_BACKOFF: if (bo_zero)     st_d = ST_SEND;
      ST_SEND:    if (ev_tx_fire)  st_d = ST_WAIT;
      ST_WAIT: begin
        if (ev_ack_take || ev_give_up) st_d = ST_IDLE;
        else if (ev_retry)             st_d = ST_SEND;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      seq_q   <= '0;
      t1_q    <= '0;
      retry_q <= '0;
      fail_q  <= 1'b0;
      smp_v_q <= 1'b0;
      off_q   <= '0;
      dly_q   <= '0;
    end else begin
      st_q    <= st_d;
      smp_v_q <= ev_ack_take;
      if (ev_tx_fire) t1_q <= local_time;
      if (ev_ack_take || ev_timeout) seq_q <= seq_q + 1'b1;
      if (ev_req_take) retry_q <= '0;
      else if (ev_retry) retry_q <= retry_q + 1'b1;
      if (ev_req_take) fail_q <= 1'b0;
      else if (ev_give_up) fail_q <= 1'b1;
      if (ev_ack_take) begin
        off_q <= calc_off;
        dly_q <= calc_dly;
      end
    end
  end

  assign tx_valid      = (st_q == ST_SEND);
  assign tx_type       = MT_SYNC;
  assign tx_seq        = seq_q;
  assign tx_ts         = local_time;
  assign sample_valid  = smp_v_q;
  assign sample_offset = off_q;
  assign sample_delay  = dly_q;
  assign sync_fail     = fail_q;
endmodule

// File: rtl/tsync_requester_chk.sv
`timescale 1ns/1ps
module tsync_requester_chk
  import tsync_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input seq_t       tx_seq,
  input logic       sample_valid,
  input logic       sync_fail,
  input logic       ev_req_take,
  input logic       ev_tx_fire,
  input logic       ev_ack_take,
  input logic       ev_timeout,
  input logic       ev_retry,
  input logic       ev_give_up
);
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_seq)));

  p_retry_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |=> (tx_valid && (tx_seq == SEQ_W'($past(tx_seq) + 1'b1))));

  p_event_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ack_take, ev_timeout, ev_tx_fire, ev_req_take}));

  p_ack_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_take |=> (sample_valid && !tx_valid));

  p_no_stray_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ack_take |=> !sample_valid);

  p_give_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_give_up |=> (sync_fail && !tx_valid));

  p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_fail && !ev_req_take) |=> sync_fail);

  p_req_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req_take |=> (!tx_valid && !sample_valid && !sync_fail));
endmodule

bind tsync_requester tsync_requester_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_seq       (tx_seq),
  .sample_valid (sample_valid),
  .sync_fail    (sync_fail),
  .ev_req_take  (ev_req_take),
  .ev_tx_fire   (ev_tx_fire),
  .ev_ack_take  (ev_ack_take),
  .ev_timeout   (ev_timeout),
  .ev_retry     (ev_retry),
  .ev_give_up   (ev_give_up)
);

// File: tb/sim_tsync_requester.sv
`timescale 1ns/1ps
module sim_tsync_requester;
  localparam logic [15:0] MASK  = 16'h003F;
  localparam int          TMO   = 40;
  localparam int          RETRY = 3;
  localparam logic [31:0] BASE  = 32'hFFFF_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] local_time = BASE;
  logic [15:0] rnd_in = '0;
  logic        rx_valid = 1'b0;
  logic [1:0]  rx_type = '0;
  logic [7:0]  rx_seq = '0;
  logic [31:0] rx_ts_recv = '0;
  logic [31:0] rx_ts_send = '0;
  logic        tx_ready = 1'b1;
  logic        tx_valid;
  logic [1:0]  tx_type;
  logic [7:0]  tx_seq;
  logic [31:0] tx_ts;
  logic        sample_valid;
  logic [31:0] sample_offset, sample_delay;
  logic        sync_fail;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsync_requester #(.RND_W(16), .BACKOFF_MASK(MASK), .TIMEOUT(TMO), .MAX_RETRY(RETRY)) u0 (
    .clk(clk), .rst_n(rst_n), .local_time(local_time), .rnd_in(rnd_in),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_seq(rx_seq),
    .rx_ts_recv(rx_ts_recv), .rx_ts_send(rx_ts_send),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_type(tx_type), .tx_seq(tx_seq), .tx_ts(tx_ts),
    .sample_valid(sample_valid), .sample_offset(sample_offset), .sample_delay(sample_delay),
    .sync_fail(sync_fail));

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Floor of half, computed by division with a correction for negative odd values.
  function automatic logic [31:0] floor_half(input longint v);
    longint q;
    q = v / 2;
    if (v < 0 && (v % 2) != 0) q = q - 1;
    return q[31:0];
  endfunction

  function automatic longint wrap_diff(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    int          s;
    d = a - b;
    s = d;
    return longint'(s);
  endfunction

  function automatic logic [31:0] model_off(input logic [31:0] t1, t2, t3, t4);
    return floor_half(wrap_diff(t2, t1) - wrap_diff(t4, t3));
  endfunction

  function automatic logic [31:0] model_dly(input logic [31:0] t1, t2, t3, t4);
    return floor_half(wrap_diff(t2, t1) + wrap_diff(t4, t3));
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
    local_time = BASE + 32'(cyc);
  endtask

  task automatic send_req(input logic [15:0] r, output int m);
    rx_valid = 1'b1; rx_type = 2'd0; rnd_in = r; m = cyc;
    step();
    rx_valid = 1'b0;
  endtask

  task automatic wait_tx(output int hs, output logic [7:0] s, output logic [31:0] t1);
    hs = -1; s = '0; t1 = '0;
    for (int i = 0; i < 3000; i++) begin
      if (tx_valid && tx_ready) begin
        hs = cyc; s = tx_seq; t1 = tx_ts;
        check("R3 tx_type", tx_type, 2'd1);
        check("R3 tx_ts", tx_ts, local_time);
        break;
      end
      step();
    end
    if (hs < 0) check("R3 handshake seen", 0, 1);
  endtask

  task automatic send_msg(input logic [1:0] ty, input logic [7:0] s,
                          input logic [31:0] t2, input logic [31:0] t3, output logic [31:0] t4);
    rx_valid = 1'b1; rx_type = ty; rx_seq = s; rx_ts_recv = t2; rx_ts_send = t3;
    t4 = local_time;
    step();
    rx_valid = 1'b0;
  endtask

  task automatic ack_and_check(input logic [7:0] s, input logic [31:0] t1, input string tag);
    logic [31:0] t2, t3, t4;
    t2 = t1 + $urandom;
    t3 = t2 + ($urandom % 1000);
    send_msg(2'd2, s, t2, t3, t4);
    check({tag, " R6 valid"}, sample_valid, 1);
    check({tag, " R6 offset"}, sample_offset, model_off(t1, t2, t3, t4));
    check({tag, " R6 delay"}, sample_delay, model_dly(t1, t2, t3, t4));
    step();
    check({tag, " R6 one-cycle"}, sample_valid, 0);
  endtask

  task automatic exchange(input logic [15:0] r, input logic [7:0] exp_seq);
    int m, hs; logic [7:0] s; logic [31:0] t1; int k;
    send_req(r, m);
    wait_tx(hs, s, t1);
    check("R2 backoff", hs - m, int'(r & MASK) + 2);
    check("R9 seq", s, exp_seq);
    k = 1 + int'($urandom % TMO);
    for (int i = 0; i < k; i++) step();
    ack_and_check(s, t1, "rand");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int m, hs, hs2; logic [7:0] s, s2, seq_exp; logic [31:0] t1, t1b, dummy;
    void'($urandom(32'd4242));
    step(); step();
    rst_n = 1'b1;
    step();
    check("R1 tx_valid", tx_valid, 0);
    check("R1 sample_valid", sample_valid, 0);
    check("R1 sync_fail", sync_fail, 0);
    check("R1 tx_seq", tx_seq, 0);
    seq_exp = 8'd0;

    // Random exchanges, plus backoff boundaries.
    for (int n = 0; n < 8; n++) begin
      exchange(16'($urandom), seq_exp); seq_exp++;
      for (int i = 0; i < 3; i++) step();
    end
    exchange(16'h0000, seq_exp); seq_exp++;
    exchange(16'hFFFF, seq_exp); seq_exp++;

    // R8: a second request during backoff does not restart it.
    send_req(16'd20, m);
    for (int i = 0; i < 3; i++) step();
    rx_valid = 1'b1; rx_type = 2'd0; rnd_in = 16'd0;
    step(); rx_valid = 1'b0;
    wait_tx(hs, s, t1);
    check("R8 backoff unchanged", hs - m, 22);
    step();
    // R5: wrong sequence number and wrong type are ignored.
    send_msg(2'd2, s + 8'd1, t1, t1, dummy);
    check("R5 bad seq no sample", sample_valid, 0);
    check("R5 bad seq still waiting", tx_valid, 0);
    send_msg(2'd1, s, t1, t1, dummy);
    check("R5 bad type no sample", sample_valid, 0);
    // R8: request while waiting is ignored.
    send_msg(2'd0, s, t1, t1, dummy);
    check("R8 req in wait ignored", tx_valid, 0);
    ack_and_check(s, t1, "R5 good ack");
    seq_exp = s + 8'd1;

    // R4: timeout, resend, stale ack ignored, last-chance ack accepted.
    send_req(16'd3, m);
    wait_tx(hs, s, t1);
    step();
    wait_tx(hs2, s2, t1b);
    check("R4 resend gap", hs2 - hs, TMO + 2);
    check("R4 resend seq", s2, s + 8'd1);
    step();
    send_msg(2'd2, s, t1, t1, dummy);
    check("R5 stale ack ignored", sample_valid, 0);
    for (int i = 0; i < TMO - 1; i++) step();
    check("R4 last-chance cycle", cyc - hs2, TMO + 1);
    ack_and_check(s2, t1b, "R4 last chance");
    check("R4 no resend after ack", tx_valid, 0);
    seq_exp = s2 + 8'd1;

    // R7: exhaust retries.
    send_req(16'd1, m);
    wait_tx(hs, s, t1);
    check("R9 seq after success", s, seq_exp);
    for (int r = 0; r < RETRY; r++) begin
      step();
      wait_tx(hs2, s2, t1b);
      check("R7 retry gap", hs2 - hs, TMO + 2);
      check("R7 retry seq", s2, s + 8'(r + 1));
      hs = hs2;
    end
    for (int i = 0; i < TMO + 2; i++) step();
    check("R7 fail set", sync_fail, 1);
    begin
      int extra = 0;
      for (int i = 0; i < 60; i++) begin
        step();
        if (tx_valid) extra++;
      end
      check("R7 no more sends", extra, 0);
    end
    check("R7 fail held", sync_fail, 1);
    seq_exp = s2 + 8'd1;
    send_req(16'd0, m);
    check("R7 fail cleared", sync_fail, 0);

    // R3: stalled ready holds the message; t1 is taken at handshake.
    tx_ready = 1'b0;
    for (int i = 0; i < 10; i++) step();
    check("R3 valid while stalled", tx_valid, 1);
    s = tx_seq;
    check("R9 seq after give-up", s, seq_exp);
    step(); step();
    check("R3 held seq", tx_seq, s);
    check("R3 ts tracks time", tx_ts, local_time);
    tx_ready = 1'b1;
    wait_tx(hs, s2, t1);
    check("R3 seq at handshake", s2, s);
    step(); step();
    ack_and_check(s2, t1, "R3 stalled");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule